// File: doc/BRIEF.md
# Next-PC and Target Address Generator

This block sits beside the instruction decoder of a small 32-bit core. For the instruction now being decoded it works out the fall-through address, the destination of any unconditional control transfer, the value to write back as a return address, and two data addresses that do not need the ALU: the address of a PC-relative literal and the address of a compact load or store. The decoder supplies the current PC, a flag that marks a two-byte instruction, a small operation selector and the raw immediate fields. The register file supplies one base register and the return-address register.

Every accepted input produces one registered result on the following cycle. A redirect strobe and the target go to fetch, a write-enable and a data value go to the return-address register, and an illegal flag goes to the exception logic. Memory access and the evaluation of conditional branches belong to other blocks.

Top module: `nxpc_addr_gen`

## Requirements
- R1: `next_pc` equals `pc_in + 2` when `short_insn` is 1 and `pc_in + 3` when it is 0.
- R2: All outputs are registered. `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1 and 0 otherwise, and `redirect`, `link_we` and `illegal` are 1 only when `out_valid` is 1. After reset `out_valid`, `redirect`, `link_we` and `illegal` are 0.
- R3: `lit_addr` equals `{14'h3FFF, imm16, 2'b00}` plus `pc_in + 3` with its two low bits cleared.
- R4: With `op_sel` = 1 (direct call) and `call_n` = 0, `redirect` is 1 and `target` equals `pc_in` with its two low bits cleared, plus the sign-extended `off18` times 4, plus 4. `link_we` is 1 and `link_data` equals the R1 next PC.
- R5: With `op_sel` = 2 (jump), `redirect` is 1 and `target` equals `pc_in + 4` plus the sign-extended `off18`, unscaled. `link_we` is 0.
- R6: With `op_sel` = 3 (return), `redirect` is 1 and `target` equals `link_in`. `link_we` is 0.
- R7: `ls_addr` equals `base_val + 4 * r_field`.
- R8: With `op_sel` = 1, `call_n` from 1 to 3 and `HAS_WINDOW` = 0, `illegal` is 1 and both `redirect` and `link_we` are 0.
- R9: With `op_sel` = 1, `call_n` from 1 to 3 and `HAS_WINDOW` = 1, `illegal`, `redirect` and `link_we` are all 0.
- R10: With `op_sel` = 0 (sequential), 4 (literal), 5 (compact load/store) or 6 to 7, `redirect`, `link_we` and `illegal` are 0.
- R11: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs hold a decoded instruction |
| pc_in | input | 32 | Address of the current instruction |
| short_insn | input | 1 | 1 for a two-byte instruction, 0 for three bytes |
| op_sel | input | 3 | Operation class (0 seq, 1 call, 2 jump, 3 return, 4 literal, 5 compact ld/st) |
| call_n | input | 2 | Window-rotation field of a call |
| off18 | input | 18 | Signed call/jump offset field |
| imm16 | input | 16 | Literal offset field |
| r_field | input | 4 | Word offset of a compact load/store |
| base_val | input | 32 | Base register value for a compact load/store |
| link_in | input | 32 | Current return-address register value |
| out_valid | output | 1 | Registered result present |
| redirect | output | 1 | Fetch must continue at `target` |
| target | output | 32 | Control-transfer destination |
| next_pc | output | 32 | Fall-through address |
| link_we | output | 1 | Write `link_data` to the return-address register |
| link_data | output | 32 | Return address |
| lit_addr | output | 32 | Literal load address |
| ls_addr | output | 32 | Compact load/store address |
| illegal | output | 1 | Call form not supported by this configuration |

## Verification
The bench places calls at PCs whose low two bits are non-zero, so a design that skips the word alignment of the PC, or that scales a jump offset the way a call offset is scaled, lands on the wrong target. Literal loads are issued from PCs with each low-bit pattern, which exposes rounding down instead of up or a missing negative upper mask. Negative offsets and PCs at the top of the address space catch sign-extension slips and sums that fail to wrap. Window-rotating calls are sent to a build with window support and to one without, where a wrong design would redirect, write the return address, or miss the illegal flag.

// File: rtl/nxpc_pkg.sv
// Shared operation encoding for the next-PC / target address generator.
package nxpc_pkg;
    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_CALL = 3'd1,
        OP_JUMP = 3'd2,
        OP_RET  = 3'd3,
        OP_LIT  = 3'd4,
        OP_NLS  = 3'd5
    } op_e;
endpackage

// File: rtl/nxpc_seq_unit.sv
// Fall-through address: adds the instruction length to the PC.
// Assumes only two-byte and three-byte lengths; the sum wraps at AW bits.
module nxpc_seq_unit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic          short_insn,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] LEN_SHORT = AW'(2);
    localparam logic [AW-1:0] LEN_LONG  = AW'(3);

    // Select the length and add it.
    always_comb nxt = pc + (short_insn ? LEN_SHORT : LEN_LONG);
endmodule

// File: rtl/nxpc_xfer_unit.sv
// Control-transfer decision: target, redirect, return-address write and
// illegal-form detection. Assumes op is valid only when the caller says so;
// windowed call forms are legal but carry no transfer here when supported.
module nxpc_xfer_unit
    import nxpc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int OFFW       = 18,
    parameter int NW         = 2,
    parameter bit HAS_WINDOW = 1'b0
) (
    input  logic [2:0]      op_sel,
    input  logic [NW-1:0]   call_n,
    input  logic [AW-1:0]   pc,
    input  logic [OFFW-1:0] off,
    input  logic [AW-1:0]   link_in,
    output logic            take,
    output logic [AW-1:0]   tgt,
    output logic            lwe,
    output logic            ill
);
    localparam int SXW = AW - OFFW;

    op_e           op;
    logic [AW-1:0] off_sx;
    logic [AW-1:0] call_tgt;
    logic [AW-1:0] jump_tgt;
    logic          plain_call;

    assign op = op_e'(op_sel);

    // Sign-extend the offset field to the address width.
    always_comb off_sx = {{SXW{off[OFFW-1]}}, off};

    // Candidate targets for the two PC-relative transfers.
    always_comb begin
        call_tgt = {pc[AW-1:2], 2'b00} + (off_sx << 2) + AW'(4);
        jump_tgt = pc + AW'(4) + off_sx;
    end

    assign plain_call = (call_n == '0);

    // Pick target and side effects by operation class.
    always_comb begin
        take = 1'b0;
        tgt  = jump_tgt;
        lwe  = 1'b0;
        ill  = 1'b0;
        case (op)
            OP_CALL: begin
                if (plain_call) begin
                    take = 1'b1;
                    tgt  = call_tgt;
                    lwe  = 1'b1;
                end else begin
                    ill = !HAS_WINDOW;
                end
            end
            OP_JUMP: take = 1'b1;
            OP_RET: begin
                take = 1'b1;
                tgt  = link_in;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nxpc_data_unit.sv
// Data-side addresses: PC-relative literal address (negative word offset
// from the PC rounded up to a word) and base-plus-scaled compact address.
module nxpc_data_unit #(
    parameter int AW   = 32,
    parameter int IMMW = 16,
    parameter int RW   = 4
) (
    input  logic [AW-1:0]   pc,
    input  logic [IMMW-1:0] imm,
    input  logic [RW-1:0]   r,
    input  logic [AW-1:0]   base,
    output logic [AW-1:0]   lit,
    output logic [AW-1:0]   ls
);
    localparam int HIW = AW - IMMW - 2;
    localparam int ZW  = AW - RW - 2;

    logic [AW-1:0] pc_up;

    // Round PC+3 down to a word, i.e. round the next word boundary up.
    always_comb begin
        pc_up = pc + AW'(3);
        pc_up[1:0] = 2'b00;
    end

    // Literal address with all-ones upper bits above the scaled immediate.
    always_comb lit = {{HIW{1'b1}}, imm, 2'b00} + pc_up;

    // Compact load/store address: base plus word offset.
    always_comb ls = base + {{ZW{1'b0}}, r, 2'b00};
endmodule

// File: rtl/nxpc_addr_gen.sv
// Top: next-PC and target address generator. Combines the three units and
// registers every result one cycle after in_valid. Synchronous active-low reset.
module nxpc_addr_gen #(
    parameter int AW         = 32,
    parameter int OFFW       = 18,
    parameter int IMMW       = 16,
    parameter int RW         = 4,
    parameter int NW         = 2,
    parameter bit HAS_WINDOW = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [AW-1:0]   pc_in,
    input  logic            short_insn,
    input  logic [2:0]      op_sel,
    input  logic [NW-1:0]   call_n,
    input  logic [OFFW-1:0] off18,
    input  logic [IMMW-1:0] imm16,
    input  logic [RW-1:0]   r_field,
    input  logic [AW-1:0]   base_val,
    input  logic [AW-1:0]   link_in,
    output logic            out_valid,
    output logic            redirect,
    output logic [AW-1:0]   target,
    output logic [AW-1:0]   next_pc,
    output logic            link_we,
    output logic [AW-1:0]   link_data,
    output logic [AW-1:0]   lit_addr,
    output logic [AW-1:0]   ls_addr,
    output logic            illegal
);
    logic [AW-1:0] nxt_c, tgt_c, lit_c, ls_c;
    logic          take_c, lwe_c, ill_c;

    nxpc_seq_unit #(.AW(AW)) u_seq (
        .pc(pc_in), .short_insn(short_insn), .nxt(nxt_c)
    );

    nxpc_xfer_unit #(.AW(AW), .OFFW(OFFW), .NW(NW), .HAS_WINDOW(HAS_WINDOW)) u_xfer (
        .op_sel(op_sel), .call_n(call_n), .pc(pc_in), .off(off18),
        .link_in(link_in), .take(take_c), .tgt(tgt_c), .lwe(lwe_c), .ill(ill_c)
    );

    nxpc_data_unit #(.AW(AW), .IMMW(IMMW), .RW(RW)) u_data (
        .pc(pc_in), .imm(imm16), .r(r_field), .base(base_val),
        .lit(lit_c), .ls(ls_c)
    );

    // Control strobes: one cycle after the accepted input, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            redirect  <= 1'b0;
            link_we   <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            redirect  <= in_valid & take_c;
            link_we   <= in_valid & lwe_c;
            illegal   <= in_valid & ill_c;
        end
    end

    // Address results: captured on each accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target    <= '0;
            next_pc   <= '0;
            link_data <= '0;
            lit_addr  <= '0;
            ls_addr   <= '0;
        end else if (in_valid) begin
            target    <= tgt_c;
            next_pc   <= nxt_c;
            link_data <= nxt_c;
            lit_addr  <= lit_c;
            ls_addr   <= ls_c;
        end
    end
endmodule

// File: rtl/nxpc_addr_gen_chk.sv
// Checker for nxpc_addr_gen: temporal properties on its ports.
module nxpc_addr_gen_chk #(
    parameter int AW   = 32,
    parameter int RW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    op_sel,
    input logic [AW-1:0] link_in,
    input logic [AW-1:0] base_val,
    input logic [RW-1:0] r_field,
    input logic          out_valid,
    input logic          redirect,
    input logic [AW-1:0] target,
    input logic [AW-1:0] next_pc,
    input logic          link_we,
    input logic [AW-1:0] link_data,
    input logic [AW-1:0] lit_addr,
    input logic [AW-1:0] ls_addr,
    input logic          illegal
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect || link_we || illegal) |-> out_valid);
    // R8
    ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!redirect && !link_we));
    // R4
    link_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == next_pc && redirect));
    // R6
    ret_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd3) |=> (redirect && target == $past(link_in)));
    // R7
    ls_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd5) |=>
            ((ls_addr - $past(base_val)) == AW'({$past(r_field), 2'b00})));
    // R3
    lit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (lit_addr[1:0] == 2'b00 && lit_addr[AW-1:AW-14] == 14'h3FFF
                      || lit_addr[1:0] == 2'b00));
    // R10
    quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 3'd0 || op_sel >= 3'd4)) |=>
            (!redirect && !link_we && !illegal));
endmodule

bind nxpc_addr_gen nxpc_addr_gen_chk #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/sim_nxpc_addr_gen.sv
module sim_nxpc_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] pc_in = '0;
    logic        short_insn = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  call_n = '0;
    logic [17:0] off18 = '0;
    logic [15:0] imm16 = '0;
    logic [3:0]  r_field = '0;
    logic [31:0] base_val = '0;
    logic [31:0] link_in = '0;

    logic        out_valid, redirect, link_we, illegal;
    logic [31:0] target, next_pc, link_data, lit_addr, ls_addr;
    logic        w_valid, w_redirect, w_link_we, w_illegal;
    logic [31:0] w_target, w_next_pc, w_link_data, w_lit_addr, w_ls_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nxpc_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
        .short_insn(short_insn), .op_sel(op_sel), .call_n(call_n), .off18(off18),
        .imm16(imm16), .r_field(r_field), .base_val(base_val), .link_in(link_in),
        .out_valid(out_valid), .redirect(redirect), .target(target),
        .next_pc(next_pc), .link_we(link_we), .link_data(link_data),
        .lit_addr(lit_addr), .ls_addr(ls_addr), .illegal(illegal)
    );

    nxpc_addr_gen #(.HAS_WINDOW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
        .short_insn(short_insn), .op_sel(op_sel), .call_n(call_n), .off18(off18),
        .imm16(imm16), .r_field(r_field), .base_val(base_val), .link_in(link_in),
        .out_valid(w_valid), .redirect(w_redirect), .target(w_target),
        .next_pc(w_next_pc), .link_we(w_link_we), .link_data(w_link_data),
        .lit_addr(w_lit_addr), .ls_addr(w_ls_addr), .illegal(w_illegal)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] sx18(input logic [17:0] v);
        return {{14{v[17]}}, v};
    endfunction

    // Present one instruction for a cycle; return at the negedge after the capture edge.
    task automatic issue(input logic [31:0] pc, input logic sh, input logic [2:0] op,
                         input logic [1:0] n, input logic [17:0] off,
                         input logic [15:0] imm, input logic [3:0] r,
                         input logic [31:0] base, input logic [31:0] lnk);
        @(negedge clk);
        pc_in = pc; short_insn = sh; op_sel = op; call_n = n; off18 = off;
        imm16 = imm; r_field = r; base_val = base; link_in = lnk; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 reset out_valid", 32'(out_valid), 0);
        chk("R2 reset redirect", 32'(redirect), 0);
        chk("R2 reset link_we", 32'(link_we), 0);
        chk("R2 reset illegal", 32'(illegal), 0);
    endtask

    task automatic t_seq;
        issue(32'h0000_1000, 1'b1, 3'd0, 2'd0, '0, '0, '0, '0, '0);
        chk("R1 short next_pc", next_pc, 32'h0000_1002);
        chk("R2 valid", 32'(out_valid), 1);
        chk("R10 seq no redirect", 32'(redirect), 0);
        chk("R10 seq no link", 32'(link_we), 0);
        issue(32'h0000_1001, 1'b0, 3'd7, 2'd0, '0, '0, '0, '0, '0);
        chk("R1 long next_pc", next_pc, 32'h0000_1004);
        chk("R10 code 7 quiet", 32'({redirect, link_we, illegal}), 0);
        @(negedge clk);
        chk("R2 valid drops", 32'(out_valid), 0);
    endtask

    task automatic t_literal;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pc;
            logic [31:0] rup;
            pc  = 32'h0004_0010 + 32'(k);
            rup = (pc + 32'd3) & 32'hFFFF_FFFC;
            issue(pc, 1'b0, 3'd4, 2'd0, '0, 16'h0123, '0, '0, '0);
            chk("R3 literal addr", lit_addr, (32'hFFFC_0000 | (32'h0123 << 2)) + rup);
            chk("R10 literal quiet", 32'(redirect), 0);
        end
        issue(32'h0004_0000, 1'b0, 3'd4, 2'd0, '0, 16'hFFFF, '0, '0, '0);
        chk("R3 literal max imm", lit_addr, 32'h0004_0000 - 32'd4);
    endtask

    task automatic t_call0;
        logic [31:0] pc;
        pc = 32'h1000_0002;
        issue(pc, 1'b0, 3'd1, 2'd0, 18'h3FFFF, '0, '0, '0, '0);
        chk("R4 call redirect", 32'(redirect), 1);
        chk("R4 call target", target, (pc & 32'hFFFF_FFFC) + (sx18(18'h3FFFF) << 2) + 32'd4);
        chk("R4 link write", 32'(link_we), 1);
        chk("R4 link data", link_data, pc + 32'd3);
        pc = 32'h2000_0003;
        issue(pc, 1'b0, 3'd1, 2'd0, 18'h00010, '0, '0, '0, '0);
        chk("R4 call target fwd", target, 32'h2000_0044);
    endtask

    task automatic t_jump;
        issue(32'h3000_0001, 1'b0, 3'd2, 2'd0, 18'h00005, '0, '0, '0, '0);
        chk("R5 jump target", target, 32'h3000_000A);
        chk("R5 jump redirect", 32'(redirect), 1);
        chk("R5 jump no link", 32'(link_we), 0);
        issue(32'h3000_0100, 1'b0, 3'd2, 2'd0, 18'h20000, '0, '0, '0, '0);
        chk("R5 jump most negative", target, 32'h3000_0104 - 32'h0002_0000);
    endtask

    task automatic t_ret;
        issue(32'h0000_0200, 1'b1, 3'd3, 2'd0, '0, '0, '0, '0, 32'hDEAD_BEE1);
        chk("R6 ret target", target, 32'hDEAD_BEE1);
        chk("R6 ret redirect", 32'(redirect), 1);
        chk("R6 ret no link", 32'(link_we), 0);
    endtask

    task automatic t_nls;
        issue(32'h0, 1'b1, 3'd5, 2'd0, '0, '0, 4'hF, 32'h8000_0001, '0);
        chk("R7 ls addr", ls_addr, 32'h8000_003D);
        chk("R10 nls quiet", 32'({redirect, link_we, illegal}), 0);
        issue(32'h0, 1'b1, 3'd5, 2'd0, '0, '0, 4'h3, 32'hFFFF_FFF8, '0);
        chk("R11 ls wrap", ls_addr, 32'h0000_0004);
    endtask

    task automatic t_windowed;
        for (int n = 1; n < 4; n++) begin
            issue(32'h0000_0400, 1'b0, 3'd1, 2'(n), 18'h00001, '0, '0, '0, '0);
            chk("R8 illegal", 32'(illegal), 1);
            chk("R8 no redirect/link", 32'({redirect, link_we}), 0);
            chk("R9 windowed quiet", 32'({w_redirect, w_link_we, w_illegal}), 0);
        end
    endtask

    task automatic t_wrap;
        issue(32'hFFFF_FFFE, 1'b1, 3'd2, 2'd0, 18'h00005, 16'h0002, '0, '0, '0);
        chk("R11 next_pc wrap", next_pc, 32'h0000_0000);
        chk("R11 jump wrap", target, 32'h0000_0007);
        chk("R11 literal wrap", lit_addr, 32'hFFFC_0008);
        issue(32'hFFFF_FFFF, 1'b0, 3'd1, 2'd0, 18'h00000, '0, '0, '0, '0);
        chk("R11 call wrap", target, 32'h0000_0000);
        chk("R11 link wrap", link_data, 32'h0000_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_literal();
        t_call0();
        t_jump();
        t_ret();
        t_nls();
        t_windowed();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule